// File: doc/BRIEF.md
# Cell Balancing Control Register Bank

This block holds the control registers of a cell-balancing sequencer and decides, from the balancing mode in force, which register writes are taken. A flat write/read bus reaches a 3-bit mode register, a per-cell switch-select register, a delay-control register, one expiration-time register per cell, a read-only completion status, a read-only balancing timer and a sticky write-reject flag. A mode of zero means balancing is off. Any other mode value is an active mode, and writing it starts that mode with a fresh timer.

The timer advances once per prescaled tick while a mode is active. A cell counts as complete when the timer reaches the expiration time that applies to it. Modes whose top bit is set are individual modes, and each cell uses its own expiration register. All other active modes are group modes, and every cell uses the first cell's expiration register. Completion bits stay set until the mode register is written again. The switch-enable output drives a cell's switch only while a mode is active, the cell is selected and the cell has not yet completed.

Top module: `cbal_regbank`

## Requirements
- R1: After reset every register reads zero (mode, switch select, delay, all expirations, status, reject, timer) and all switch enables are low.
- R2: A write of a non-zero value to the mode register (address 0, bits [2:0]) stores it and returns the timer to zero in the same clock edge, even if a mode is already running.
- R3: While the mode is non-zero the timer, readable at address 5, increments once every PRESCALE clock cycles, counted from the edge that launched the mode, and stops at its all-ones value. While the mode is zero the timer holds its value.
- R4: A write to the switch-select register (address 1) or the delay register (address 2) is refused while the mode is 001 or any mode with bit 2 set. In modes 000, 010 and 011 it is accepted.
- R5: The expiration register of the first cell (address 16) refuses writes whenever the mode is non-zero.
- R6: The expiration registers of the other cells (addresses 17 upward, one per cell) refuse writes only while mode bit 2 is set.
- R7: A refused write leaves its target unchanged and sets the reject flag (address 4, bit 0). The flag stays set until a write to address 4 with bit 0 equal to 1. A write there with bit 0 equal to 0 leaves the flag set.
- R8: While a mode is active, status bit i (address 3) sets on the clock edge after the timer is at or above that cell's expiration time. That time is the cell's own register when mode bit 2 is set and the first cell's register otherwise. Once set, a bit stays set.
- R9: Every write to the mode register, whether it disables or starts a mode, clears all status bits on that edge.
- R10: Every register reads back its current value at any time, including while it is locked. Writes to the status and timer addresses change nothing and do not set the reject flag.
- R11: Switch enable i is high exactly when the mode is non-zero, switch-select bit i is set and status bit i is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address, combinational read path |
| rd_data | output | DATA_W | Contents of the addressed register, zero-extended |
| sw_on | output | NUM_CELLS | Per-cell balancing switch enable |

## Verification
The lockout rules are swept over all eight mode values. In each mode a write is tried to the switch-select register, the delay register and every expiration register, so the three different lock conditions are told apart. This also checks that the reject flag follows only the refused writes. The timer and completion path is run once in a group mode with unequal per-cell expiration values, which shows that only the first cell's value counts. It is run again in an individual mode with staggered per-cell values, which shows each bit setting on its own edge and its switch dropping. Restart, disable-and-hold, saturation of the timer at its maximum, and the exact edge on which a completion bit appears are checked cycle by cycle against arithmetic on the prescale ratio.

// File: rtl/cbal_pkg.sv
`timescale 1ns/1ps
package cbal_pkg;

    localparam int CB_CELLS_DEF    = 14;
    localparam int CB_TIME_W_DEF   = 8;
    localparam int CB_DLY_W_DEF    = 8;
    localparam int CB_DATA_W_DEF   = 16;
    localparam int CB_ADDR_W_DEF   = 5;
    localparam int CB_PRESCALE_DEF = 4;

    // register addresses
    localparam int unsigned A_MODE     = 0;
    localparam int unsigned A_SWSEL    = 1;
    localparam int unsigned A_DELAY    = 2;
    localparam int unsigned A_STATUS   = 3;
    localparam int unsigned A_REJECT   = 4;
    localparam int unsigned A_TIMER    = 5;
    localparam int unsigned A_EXP_BASE = 16;

    typedef logic [2:0] cb_mode_t;

    // decoded write controls for the scalar registers
    typedef struct packed {
        logic mode_we;
        logic swsel_we;
        logic delay_we;
        logic rej_set;
        logic rej_clr;
    } cb_wctl_t;

    function automatic logic cb_active(cb_mode_t m);
        return m != 3'b000;
    endfunction

    function automatic logic cb_individual(cb_mode_t m);
        return m[2];
    endfunction

    // switch-select and delay registers frozen in 001 and 1xx
    function automatic logic cb_swsel_locked(cb_mode_t m);
        return (m == 3'b001) || m[2];
    endfunction

    // first expiration register frozen in any active mode,
    // the remaining ones only in the individual modes
    function automatic logic cb_exp_locked(cb_mode_t m, int idx);
        return (idx == 0) ? cb_active(m) : cb_individual(m);
    endfunction

endpackage

// File: rtl/cbal_wr_gate.sv
`timescale 1ns/1ps
module cbal_wr_gate
    import cbal_pkg::*;
#(
    parameter int ADDR_W    = CB_ADDR_W_DEF,
    parameter int NUM_CELLS = CB_CELLS_DEF
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 wr_bit0,
    input  cb_mode_t             mode,
    output cb_wctl_t             wctl,
    output logic [NUM_CELLS-1:0] exp_we
);

    logic                 hit_mode;
    logic                 hit_swsel;
    logic                 hit_delay;
    logic                 hit_reject;
    logic                 sw_lock;
    logic [NUM_CELLS-1:0] exp_refused;

    assign hit_mode   = wr_en && (wr_addr == ADDR_W'(A_MODE));
    assign hit_swsel  = wr_en && (wr_addr == ADDR_W'(A_SWSEL));
    assign hit_delay  = wr_en && (wr_addr == ADDR_W'(A_DELAY));
    assign hit_reject = wr_en && (wr_addr == ADDR_W'(A_REJECT));
    assign sw_lock    = cb_swsel_locked(mode);

    for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_exp
        logic hit_exp;
        logic lock_exp;
        assign hit_exp         = wr_en && (wr_addr == ADDR_W'(A_EXP_BASE + gi));
        assign lock_exp        = cb_exp_locked(mode, gi);
        assign exp_we[gi]      = hit_exp && !lock_exp;
        assign exp_refused[gi] = hit_exp && lock_exp;
    end

    always_comb begin
        wctl          = '0;
        wctl.mode_we  = hit_mode;
        wctl.swsel_we = hit_swsel && !sw_lock;
        wctl.delay_we = hit_delay && !sw_lock;
        wctl.rej_set  = ((hit_swsel || hit_delay) && sw_lock) || (|exp_refused);
        wctl.rej_clr  = hit_reject && wr_bit0;
    end

endmodule

// File: rtl/cbal_timer.sv
`timescale 1ns/1ps
module cbal_timer #(
    parameter int TIME_W   = 8,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    output logic [TIME_W-1:0] timer
);

    localparam int              PSC_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(PRESCALE - 1);
    localparam logic [TIME_W-1:0] T_MAX   = '1;

    logic [PSC_W-1:0]  psc_q;
    logic [TIME_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            psc_q <= '0;
            tmr_q <= '0;
        end else if (run) begin
            if (psc_q == PSC_LAST) begin
                psc_q <= '0;
                if (tmr_q != T_MAX) begin
                    tmr_q <= tmr_q + 1'b1;
                end
            end else begin
                psc_q <= psc_q + 1'b1;
            end
        end
    end

    assign timer = tmr_q;

endmodule

// File: rtl/cbal_status.sv
`timescale 1ns/1ps
module cbal_status #(
    parameter int NUM_CELLS = 14,
    parameter int TIME_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic                        run,
    input  logic                        individual,
    input  logic [TIME_W-1:0]           timer,
    input  logic [NUM_CELLS*TIME_W-1:0] exp_flat,
    output logic [NUM_CELLS-1:0]        status
);

    logic [NUM_CELLS-1:0] reached;
    logic [NUM_CELLS-1:0] status_q;

    for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cmp
        logic [TIME_W-1:0] limit;
        assign limit       = individual ? exp_flat[gi*TIME_W +: TIME_W]
                                        : exp_flat[0 +: TIME_W];
        assign reached[gi] = timer >= limit;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            status_q <= '0;
        end else if (run) begin
            status_q <= status_q | reached;
        end
    end

    assign status = status_q;

endmodule

// File: rtl/cbal_regbank.sv
`timescale 1ns/1ps
module cbal_regbank
    import cbal_pkg::*;
#(
    parameter int NUM_CELLS = CB_CELLS_DEF,
    parameter int TIME_W    = CB_TIME_W_DEF,
    parameter int DLY_W     = CB_DLY_W_DEF,
    parameter int DATA_W    = CB_DATA_W_DEF,
    parameter int ADDR_W    = CB_ADDR_W_DEF,
    parameter int PRESCALE  = CB_PRESCALE_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_CELLS-1:0] sw_on
);

    cb_mode_t             mode_q;
    logic [NUM_CELLS-1:0] swsel_q;
    logic [DLY_W-1:0]     delay_q;
    logic [TIME_W-1:0]    exp_q [NUM_CELLS];
    logic                 reject_q;

    cb_wctl_t                    wctl;
    logic [NUM_CELLS-1:0]        exp_we;
    logic [NUM_CELLS*TIME_W-1:0] exp_flat;
    logic [TIME_W-1:0]           timer;
    logic [NUM_CELLS-1:0]        status;
    logic                        restart;
    logic                        run;
    logic                        unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    cbal_wr_gate #(
        .ADDR_W    (ADDR_W),
        .NUM_CELLS (NUM_CELLS)
    ) u_gate (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bit0 (wr_data[0]),
        .mode    (mode_q),
        .wctl    (wctl),
        .exp_we  (exp_we)
    );

    assign restart = wctl.mode_we && (wr_data[2:0] != 3'b000);
    assign run     = cb_active(mode_q) && !wctl.mode_we;

    cbal_timer #(
        .TIME_W   (TIME_W),
        .PRESCALE (PRESCALE)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (run),
        .timer   (timer)
    );

    cbal_status #(
        .NUM_CELLS (NUM_CELLS),
        .TIME_W    (TIME_W)
    ) u_status (
        .clk        (clk),
        .rst        (rst),
        .clear      (wctl.mode_we),
        .run        (run),
        .individual (cb_individual(mode_q)),
        .timer      (timer),
        .exp_flat   (exp_flat),
        .status     (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            swsel_q  <= '0;
            delay_q  <= '0;
            reject_q <= 1'b0;
        end else begin
            if (wctl.mode_we) begin
                mode_q <= wr_data[2:0];
            end
            if (wctl.swsel_we) begin
                swsel_q <= wr_data[NUM_CELLS-1:0];
            end
            if (wctl.delay_we) begin
                delay_q <= wr_data[DLY_W-1:0];
            end
            if (wctl.rej_set) begin
                reject_q <= 1'b1;
            end else if (wctl.rej_clr) begin
                reject_q <= 1'b0;
            end
        end
    end

    for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_expreg
        always_ff @(posedge clk) begin
            if (rst) begin
                exp_q[gi] <= '0;
            end else if (exp_we[gi]) begin
                exp_q[gi] <= wr_data[TIME_W-1:0];
            end
        end
        assign exp_flat[gi*TIME_W +: TIME_W] = exp_q[gi];
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_MODE):   rd_data[2:0]           = mode_q;
            ADDR_W'(A_SWSEL):  rd_data[NUM_CELLS-1:0] = swsel_q;
            ADDR_W'(A_DELAY):  rd_data[DLY_W-1:0]     = delay_q;
            ADDR_W'(A_STATUS): rd_data[NUM_CELLS-1:0] = status;
            ADDR_W'(A_REJECT): rd_data[0]             = reject_q;
            ADDR_W'(A_TIMER):  rd_data[TIME_W-1:0]    = timer;
            default: begin
                for (int i = 0; i < NUM_CELLS; i++) begin
                    if (rd_addr == ADDR_W'(A_EXP_BASE + i)) begin
                        rd_data[TIME_W-1:0] = exp_q[i];
                    end
                end
            end
        endcase
    end

    assign sw_on = {NUM_CELLS{cb_active(mode_q)}} & swsel_q & ~status;

endmodule

// File: rtl/cbal_regbank_chk.sv
`timescale 1ns/1ps
module cbal_regbank_chk
    import cbal_pkg::*;
#(
    parameter int NUM_CELLS = CB_CELLS_DEF,
    parameter int TIME_W    = CB_TIME_W_DEF,
    parameter int DATA_W    = CB_DATA_W_DEF,
    parameter int ADDR_W    = CB_ADDR_W_DEF
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [DATA_W-1:0]    wr_data,
    input logic [2:0]           mode,
    input logic [TIME_W-1:0]    timer,
    input logic [NUM_CELLS-1:0] status,
    input logic [NUM_CELLS-1:0] swsel,
    input logic [TIME_W-1:0]    exp1,
    input logic                 reject,
    input logic [NUM_CELLS-1:0] sw_on
);

    logic unused_chk_bits;
    assign unused_chk_bits = ^wr_data;

    logic mode_wr;
    assign mode_wr = wr_en && (wr_addr == ADDR_W'(A_MODE));

    // R2: a launch returns the timer to zero
    p_launch_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && wr_data[2:0] != 3'b000) |=> (timer == '0));

    // R3: timer moves by at most one step per cycle while active
    p_timer_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mode != 3'b000 && !mode_wr) |=>
        (timer == $past(timer) || timer == TIME_W'($past(timer) + 1'b1)));

    // R4 and R7: refused switch-select write keeps value and flags reject
    p_swsel_lock_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(A_SWSEL) && (mode == 3'b001 || mode[2])) |=>
        ($stable(swsel) && reject));

    // R5: first expiration register frozen while active
    p_exp1_lock_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(A_EXP_BASE) && mode != 3'b000) |=>
        ($stable(exp1) && reject));

    // R8: completion bits never drop while the mode runs undisturbed
    p_status_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (mode != 3'b000 && !mode_wr) |=>
        ((status & $past(status)) == $past(status)));

    // R9: any mode write clears completion
    p_status_clear_r9: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (status == '0));

    // R11: no switch driven when balancing is off
    p_idle_switch_r11: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b000) |-> (sw_on == '0));

endmodule

bind cbal_regbank cbal_regbank_chk #(
    .NUM_CELLS (NUM_CELLS),
    .TIME_W    (TIME_W),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode    (mode_q),
    .timer   (timer),
    .status  (status),
    .swsel   (swsel_q),
    .exp1    (exp_q[0]),
    .reject  (reject_q),
    .sw_on   (sw_on)
);

// File: tb/test_cbal_regbank.sv
`timescale 1ns/1ps
module test_cbal_regbank;

    localparam int NC   = 14;
    localparam int TW   = 8;
    localparam int DW   = 16;
    localparam int AW   = 5;
    localparam int PS   = 4;
    localparam int CMASK = (1 << NC) - 1;
    localparam int TMAX  = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NC-1:0] sw_on;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int sw_m;
    int dly_m;
    int exp_m [NC];

    always #2 clk = ~clk;

    cbal_regbank i_cbal_regbank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sw_on   (sw_on)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = DW'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = AW'(a);
        #0.2;
        d = int'(rd_data);
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        int v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int t_hold;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state over the whole address space
        for (int a = 0; a < 32; a++) rd_chk("R1 reset readback", a, 0);
        chk("R1 switches low", int'(sw_on), 0);

        // preload in mode 000, all writes accepted
        sw_m = 0; dly_m = 0;
        for (int i = 0; i < NC; i++) begin
            exp_m[i] = (3 * i + 2) & TMAX;
            wr(16 + i, exp_m[i]);
        end
        for (int i = 0; i < NC; i++) rd_chk("R6 exp preload", 16 + i, exp_m[i]);
        rd_chk("R7 no reject in mode 0", 4, 0);

        // lockout sweep over every mode value
        for (int m = 0; m < 8; m++) begin
            bit swl;
            wr(0, m);
            rd_chk("R2 mode stored", 0, m);
            swl = (m == 1) || (m >= 4);
            v = (m * 1237 + 5) & CMASK;
            wr(1, v);
            if (!swl) sw_m = v;
            rd_chk("R4 switch select", 1, sw_m);
            rd_chk("R7 reject after switch write", 4, swl ? 1 : 0);
            wr(4, 0);
            rd_chk("R7 zero write keeps flag", 4, swl ? 1 : 0);
            wr(4, 1);
            rd_chk("R7 flag cleared", 4, 0);
            v = (m * 29 + 3) & 8'hFF;
            wr(2, v);
            if (!swl) dly_m = v;
            rd_chk("R4 delay", 2, dly_m);
            rd_chk("R7 reject after delay write", 4, swl ? 1 : 0);
            wr(4, 1);
            for (int i = 0; i < NC; i++) begin
                bit lk;
                lk = (i == 0) ? (m != 0) : (m >= 4);
                v = (m * 16 + i + 100) & TMAX;
                wr(16 + i, v);
                if (!lk) exp_m[i] = v;
                if (i == 0) rd_chk("R5 first exp", 16, exp_m[0]);
                else        rd_chk("R6 other exp", 16 + i, exp_m[i]);
                rd_chk("R7 reject after exp write", 4, lk ? 1 : 0);
                wr(4, 1);
            end
        end

        // group mode: only the first expiration counts
        wr(0, 0);
        wr(16, 5);
        for (int i = 1; i < NC; i++) wr(16 + i, 200 - i);
        wr(1, CMASK);
        wr(0, 2);
        rd_chk("R2 timer zero at launch", 5, 0);
        rd_chk("R9 status clear at launch", 3, 0);
        for (int n = 1; n <= 40; n++) begin
            int st;
            @(posedge clk); #0.5;
            st = (((n - 1) / PS) >= 5) ? CMASK : 0;
            rd_chk("R3 timer group", 5, n / PS);
            rd_chk("R8 status group", 3, st);
            chk("R11 switches group", int'(sw_on), CMASK & ~st);
        end

        // individual mode: staggered per-cell times
        wr(0, 0);
        chk("R11 switches off when disabled", int'(sw_on), 0);
        rd_chk("R9 status cleared by disable", 3, 0);
        for (int i = 0; i < NC; i++) wr(16 + i, 2 * i);
        wr(1, 14'h2AAB);
        wr(0, 5);
        for (int n = 1; n <= 120; n++) begin
            int st;
            st = 0;
            for (int i = 0; i < NC; i++)
                if (((n - 1) / PS) >= 2 * i) st |= (1 << i);
            @(posedge clk); #0.5;
            rd_chk("R8 status individual", 3, st);
            chk("R11 switches individual", int'(sw_on), 14'h2AAB & ~st);
        end

        // restart while running
        wr(0, 5);
        rd_chk("R2 restart timer zero", 5, 0);
        rd_chk("R9 restart clears status", 3, 0);

        // disable holds the timer
        repeat (9) @(posedge clk);
        #0.5;
        rd(5, t_hold);
        wr(0, 0);
        rd_chk("R3 timer held at disable", 5, t_hold);
        repeat (10) @(posedge clk);
        #0.5;
        rd_chk("R3 timer still held", 5, t_hold);
        rd_chk("R9 status zero after disable", 3, 0);

        // read-only addresses ignore writes
        wr(3, 16'hFFFF);
        wr(5, 16'h00FF);
        rd_chk("R10 status unaffected", 3, 0);
        rd_chk("R10 timer unaffected", 5, t_hold);
        rd_chk("R10 no reject", 4, 0);

        // saturation and exact completion edge
        wr(16, TMAX);
        wr(0, 1);
        repeat (1020) @(posedge clk);
        #0.5;
        rd_chk("R3 timer at max", 5, TMAX);
        rd_chk("R8 status not yet", 3, 0);
        @(posedge clk); #0.5;
        rd_chk("R8 status on edge", 3, CMASK);
        repeat (60) @(posedge clk);
        #0.5;
        rd_chk("R3 timer saturated", 5, TMAX);
        rd_chk("R10 locked exp readable", 16, TMAX);
        rd_chk("R10 locked switch readable", 1, 14'h2AAB);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule